// File: doc/BRIEF.md
# Graded Standby Power Sequencer

This block sequences the power state of a signal-processing core through four operating levels: full operation, a light standby with the compute units switched off, a deeper standby with only the clock generator (PLL) running, and sleep, where every rail is off except this small always-on sequencer. Software asks for a standby level through a request strobe carrying a 2-bit level code. A wake event brings the core back to full operation.

Going down is immediate: the rails for the chosen level drop in the cycle after the request. Coming back up is staged. From sleep the sequencer first enables the PLL and raises a frequency-ramp request. It holds there until the PLL reports lock. It then enables the peripherals, waits a fixed settle count, enables the compute units and waits a second settle count before it reports full operation. Waking from the shallower levels enters this staircase at the step that matches the rails already on. A software request that arrives while a wake sequence runs is held and carried out once the sequence has finished.

Top module: `pwr_level_ctrl`

## Requirements
- R1: Out of reset the block is in full operation: `pll_en_o`, `periph_en_o` and `compute_en_o` are high, `pll_ramp_req_o` is low and `mode_o` is 00.
- R2: A request with level code 01 accepted in full operation gives, one cycle later, compute off, peripherals and PLL on, and `mode_o` = 01.
- R3: A request with level code 10, accepted in full operation or in the code-01 level, gives one cycle later only the PLL on, with `mode_o` = 10.
- R4: A request with level code 11, accepted in full operation or in a shallower standby level, turns all three enables off one cycle later, with `mode_o` = 11.
- R5: A wake event in sleep gives, one cycle later, the PLL enabled and `pll_ramp_req_o` high while the peripheral and compute enables stay low. This state holds for as long as `pll_lock_ack_i` is low. In the cycle after the acknowledgement is sampled high, the peripherals are enabled and the ramp request drops.
- R6: Once the peripherals have been enabled by a wake sequence, compute stays off for PERI_SETTLE cycles and then turns on. After COMP_SETTLE more cycles, `mode_o` becomes 00.
- R7: A wake from code 10 skips the ramp step and never raises `pll_ramp_req_o`: peripherals come on one cycle after the wake. A wake from code 01 starts at the compute step: compute comes on one cycle after the wake.
- R8: While a wake sequence runs, `mode_o` keeps the code of the level being left, until the cycle in which the sequence completes.
- R9: These inputs are discarded: a request with code 00; a request in a standby level for the same or a shallower level; a wake event in full operation or during a wake sequence.
- R10: A request accepted during a wake sequence, or in the cycle of the wake event, is held. It is applied in the cycle after `mode_o` first reads 00, so 00 shows for exactly one cycle. A later held request replaces an earlier one.
- R11: `pll_ramp_req_o` is high only while the PLL is enabled and the peripherals are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lvl_req_i | input | 1 | Software standby request strobe |
| lvl_code_i | input | 2 | Requested level: 01, 10 or 11 (00 means no request) |
| wake_i | input | 1 | Wake event |
| pll_lock_ack_i | input | 1 | PLL ramp finished / locked acknowledgement |
| pll_en_o | output | 1 | PLL power enable |
| periph_en_o | output | 1 | Peripheral power enable |
| compute_en_o | output | 1 | Compute unit power enable |
| pll_ramp_req_o | output | 1 | Request to ramp the PLL frequency |
| mode_o | output | 2 | Current level: 00 full, 01 compute off, 10 PLL only, 11 sleep |

## Verification
A wrong state register shows at the enable pins in the next cycle: every state decodes to its own combination of enables, ramp request and mode, so a jump to the wrong step breaks the rail ordering (compute without peripherals, peripherals without PLL) or the mode code at once. A settle counter that loses a cycle shows only when compute rises or the mode returns to 00, which can be up to PERI_SETTLE + COMP_SETTLE cycles after the wake. The bench therefore samples those edges cycle by cycle. A lost or early held request shows one cycle after the sequence ends, as a missing or premature drop of the rails.

// File: rtl/pwr_level_pkg.sv
package pwr_level_pkg;

    typedef enum logic [2:0] {
        ST_FULL  = 3'd0,
        ST_LVL2  = 3'd1,
        ST_LVL1  = 3'd2,
        ST_SLEEP = 3'd3,
        ST_RAMP  = 3'd4,
        ST_PSET  = 3'd5,
        ST_CSET  = 3'd6
    } pwr_state_e;

    localparam logic [1:0] MODE_FULL  = 2'b00;
    localparam logic [1:0] MODE_LVL2  = 2'b01;
    localparam logic [1:0] MODE_LVL1  = 2'b10;
    localparam logic [1:0] MODE_SLEEP = 2'b11;

    typedef struct packed {
        logic pll;
        logic periph;
        logic compute;
        logic ramp;
    } rail_t;

    function automatic pwr_state_e code_to_state(logic [1:0] code);
        case (code)
            MODE_LVL2:  return ST_LVL2;
            MODE_LVL1:  return ST_LVL1;
            MODE_SLEEP: return ST_SLEEP;
            default:    return ST_FULL;
        endcase
    endfunction

endpackage

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic [W-1:0] limit_i,
    output logic         last_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (!last_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == (limit_i - 1'b1));

endmodule

// File: rtl/pwr_req_hold.sv
module pwr_req_hold (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       req_i,
    input  logic [1:0] code_i,
    input  logic       capture_i,
    input  logic       clear_i,
    output logic       pend_o,
    output logic [1:0] pend_code_o
);
    typedef struct packed {
        logic       valid;
        logic [1:0] code;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (capture_i && req_i && (code_i != 2'b00)) begin
            hold_d.valid = 1'b1;
            hold_d.code  = code_i;
        end else if (clear_i) begin
            hold_d.valid = 1'b0;
            hold_d.code  = 2'b00;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign pend_o      = hold_q.valid;
    assign pend_code_o = hold_q.code;

endmodule

// File: rtl/pwr_rail_decode.sv
module pwr_rail_decode
    import pwr_level_pkg::*;
(
    input  pwr_state_e  state_i,
    input  logic [1:0]  origin_i,
    output rail_t       rail_o,
    output logic [1:0]  mode_o
);
    always_comb begin
        rail_o = '0;
        mode_o = MODE_FULL;
        case (state_i)
            ST_FULL: begin
                rail_o = '{pll: 1'b1, periph: 1'b1, compute: 1'b1, ramp: 1'b0};
                mode_o = MODE_FULL;
            end
            ST_LVL2: begin
                rail_o = '{pll: 1'b1, periph: 1'b1, compute: 1'b0, ramp: 1'b0};
                mode_o = MODE_LVL2;
            end
            ST_LVL1: begin
                rail_o = '{pll: 1'b1, periph: 1'b0, compute: 1'b0, ramp: 1'b0};
                mode_o = MODE_LVL1;
            end
            ST_SLEEP: begin
                rail_o = '0;
                mode_o = MODE_SLEEP;
            end
            ST_RAMP: begin
                rail_o = '{pll: 1'b1, periph: 1'b0, compute: 1'b0, ramp: 1'b1};
                mode_o = origin_i;
            end
            ST_PSET: begin
                rail_o = '{pll: 1'b1, periph: 1'b1, compute: 1'b0, ramp: 1'b0};
                mode_o = origin_i;
            end
            ST_CSET: begin
                rail_o = '{pll: 1'b1, periph: 1'b1, compute: 1'b1, ramp: 1'b0};
                mode_o = origin_i;
            end
            default: begin
                rail_o = '0;
                mode_o = MODE_SLEEP;
            end
        endcase
    end

endmodule

// File: rtl/pwr_level_ctrl.sv
module pwr_level_ctrl
    import pwr_level_pkg::*;
#(
    parameter int unsigned PERI_SETTLE = 4,
    parameter int unsigned COMP_SETTLE = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       lvl_req_i,
    input  logic [1:0] lvl_code_i,
    input  logic       wake_i,
    input  logic       pll_lock_ack_i,
    output logic       pll_en_o,
    output logic       periph_en_o,
    output logic       compute_en_o,
    output logic       pll_ramp_req_o,
    output logic [1:0] mode_o
);
    localparam int unsigned MAX_SETTLE = (PERI_SETTLE > COMP_SETTLE) ? PERI_SETTLE : COMP_SETTLE;
    localparam int unsigned CNT_W      = $clog2(MAX_SETTLE + 1);
    localparam logic [CNT_W-1:0] PERI_LIM = CNT_W'(PERI_SETTLE);
    localparam logic [CNT_W-1:0] COMP_LIM = CNT_W'(COMP_SETTLE);

    typedef struct packed {
        pwr_state_e state;
        logic [1:0] origin;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic             pend;
    logic [1:0]       pend_code;
    logic             capture;
    logic             clear;
    logic             new_req;
    logic             eff_req;
    logic [1:0]       eff_code;
    logic             timer_clr;
    logic             timer_last;
    logic [CNT_W-1:0] timer_limit;
    rail_t            rail;

    assign new_req  = lvl_req_i && (lvl_code_i != 2'b00);
    assign eff_req  = new_req || pend;
    assign eff_code = new_req ? lvl_code_i : pend_code;

    always_comb begin
        fsm_d   = fsm_q;
        capture = 1'b0;
        clear   = 1'b0;
        case (fsm_q.state)
            ST_FULL: begin
                if (eff_req) begin
                    fsm_d.state = code_to_state(eff_code);
                    clear       = 1'b1;
                end
            end
            ST_LVL2, ST_LVL1, ST_SLEEP: begin
                if (wake_i) begin
                    capture      = 1'b1;
                    fsm_d.origin = mode_o;
                    if (fsm_q.state == ST_SLEEP) begin
                        fsm_d.state = ST_RAMP;
                    end else if (fsm_q.state == ST_LVL1) begin
                        fsm_d.state = ST_PSET;
                    end else begin
                        fsm_d.state = ST_CSET;
                    end
                end else if (eff_req && (eff_code > mode_o)) begin
                    fsm_d.state = code_to_state(eff_code);
                end
            end
            ST_RAMP: begin
                capture = 1'b1;
                if (pll_lock_ack_i) begin
                    fsm_d.state = ST_PSET;
                end
            end
            ST_PSET: begin
                capture = 1'b1;
                if (timer_last) begin
                    fsm_d.state = ST_CSET;
                end
            end
            ST_CSET: begin
                capture = 1'b1;
                if (timer_last) begin
                    fsm_d.state  = ST_FULL;
                    fsm_d.origin = MODE_FULL;
                end
            end
            default: begin
                fsm_d.state  = ST_FULL;
                fsm_d.origin = MODE_FULL;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= '{state: ST_FULL, origin: MODE_FULL};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign timer_clr   = (fsm_d.state != fsm_q.state);
    assign timer_limit = (fsm_q.state == ST_PSET) ? PERI_LIM : COMP_LIM;

    pwr_settle_timer #(
        .W (CNT_W)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (timer_clr),
        .limit_i (timer_limit),
        .last_o  (timer_last)
    );

    pwr_req_hold u_hold (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_i       (lvl_req_i),
        .code_i      (lvl_code_i),
        .capture_i   (capture),
        .clear_i     (clear),
        .pend_o      (pend),
        .pend_code_o (pend_code)
    );

    pwr_rail_decode u_decode (
        .state_i  (fsm_q.state),
        .origin_i (fsm_q.origin),
        .rail_o   (rail),
        .mode_o   (mode_o)
    );

    assign pll_en_o       = rail.pll;
    assign periph_en_o    = rail.periph;
    assign compute_en_o   = rail.compute;
    assign pll_ramp_req_o = rail.ramp;

endmodule

// File: rtl/pwr_level_ctrl_chk.sv
module pwr_level_ctrl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       pll_lock_ack_i,
    input logic       pll_en_o,
    input logic       periph_en_o,
    input logic       compute_en_o,
    input logic       pll_ramp_req_o,
    input logic [1:0] mode_o
);
    assert_full_rails_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'b00) |-> (pll_en_o && periph_en_o && compute_en_o && !pll_ramp_req_o));

    assert_lvl2_rails_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'b01) |-> (pll_en_o && periph_en_o));

    assert_periph_needs_pll_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        periph_en_o |-> pll_en_o);

    assert_compute_needs_periph_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        compute_en_o |-> periph_en_o);

    assert_pll_rise_ramps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pll_en_o) |-> pll_ramp_req_o);

    assert_wait_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pll_ramp_req_o && !pll_lock_ack_i) |=> (pll_ramp_req_o && !periph_en_o));

    assert_periph_rise_no_compute_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(periph_en_o) |-> !compute_en_o);

    assert_compute_rise_in_wake_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(compute_en_o) |-> (mode_o != 2'b00));

    assert_ramp_only_pll_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pll_ramp_req_o |-> (pll_en_o && !periph_en_o));

endmodule

bind pwr_level_ctrl pwr_level_ctrl_chk u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pll_lock_ack_i (pll_lock_ack_i),
    .pll_en_o       (pll_en_o),
    .periph_en_o    (periph_en_o),
    .compute_en_o   (compute_en_o),
    .pll_ramp_req_o (pll_ramp_req_o),
    .mode_o         (mode_o)
);

// File: tb/pwr_level_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_level_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [1:0] code = 2'b00;
    logic       wake = 1'b0;
    logic       ack = 1'b0;
    logic       pll_en, periph_en, compute_en, ramp_req;
    logic [1:0] mode;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_level_ctrl #(
        .PERI_SETTLE (4),
        .COMP_SETTLE (3)
    ) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .lvl_req_i      (req),
        .lvl_code_i     (code),
        .wake_i         (wake),
        .pll_lock_ack_i (ack),
        .pll_en_o       (pll_en),
        .periph_en_o    (periph_en),
        .compute_en_o   (compute_en),
        .pll_ramp_req_o (ramp_req),
        .mode_o         (mode)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // expected: {pll, periph, compute, ramp}, mode
    task automatic chk(string tag, logic [3:0] exp_rails, logic [1:0] exp_mode);
        logic [5:0] got, exp;
        got = {pll_en, periph_en, compute_en, ramp_req, mode};
        exp = {exp_rails, exp_mode};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: rails/mode got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic send_req(logic [1:0] c);
        req = 1'b1;
        code = c;
        tick(1);
        req = 1'b0;
        code = 2'b00;
    endtask

    task automatic pulse_wake();
        wake = 1'b1;
        tick(1);
        wake = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset state", 4'b1110, 2'b00);
    endtask

    task automatic t_ignored_in_full();
        pulse_wake();
        chk("R9 wake in full ignored", 4'b1110, 2'b00);
        send_req(2'b00);
        chk("R9 code 00 ignored", 4'b1110, 2'b00);
    endtask

    task automatic t_descend();
        send_req(2'b01);
        chk("R2 level 01 entry", 4'b1100, 2'b01);
        send_req(2'b10);
        chk("R3 deeper to level 10", 4'b1000, 2'b10);
        send_req(2'b01);
        chk("R9 shallower request dropped", 4'b1000, 2'b10);
        send_req(2'b10);
        chk("R9 same-level request dropped", 4'b1000, 2'b10);
    endtask

    task automatic t_wake_lvl1();
        pulse_wake();
        chk("R7 lvl1 wake periph on, no ramp", 4'b1100, 2'b10);
        tick(3);
        chk("R6 compute still off at settle end", 4'b1100, 2'b10);
        tick(1);
        chk("R6 compute on after periph settle R8", 4'b1110, 2'b10);
        tick(2);
        chk("R8 mode held in compute settle", 4'b1110, 2'b10);
        tick(1);
        chk("R6 sequence complete", 4'b1110, 2'b00);
    endtask

    task automatic t_sleep_wake();
        send_req(2'b11);
        chk("R4 sleep all off", 4'b0000, 2'b11);
        tick(3);
        chk("R4 sleep holds", 4'b0000, 2'b11);
        pulse_wake();
        chk("R5 ramp step", 4'b1001, 2'b11);
        tick(5);
        chk("R5 waits for lock", 4'b1001, 2'b11);
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        chk("R5 periph on after lock", 4'b1100, 2'b11);
        tick(4);
        chk("R8 compute on, mode still sleep", 4'b1110, 2'b11);
        tick(3);
        chk("R6 full after sleep wake", 4'b1110, 2'b00);
    endtask

    task automatic t_wake_lvl2();
        send_req(2'b01);
        chk("R2 re-entry", 4'b1100, 2'b01);
        pulse_wake();
        chk("R7 lvl2 wake compute on", 4'b1110, 2'b01);
        wake = 1'b1;
        tick(2);
        wake = 1'b0;
        chk("R9 wake during sequence ignored", 4'b1110, 2'b01);
        tick(1);
        chk("R7 lvl2 wake complete", 4'b1110, 2'b00);
    endtask

    task automatic t_held_req();
        send_req(2'b10);
        chk("R3 lvl1 from full", 4'b1000, 2'b10);
        pulse_wake();
        send_req(2'b11);
        send_req(2'b01);
        chk("R10 request not applied mid-sequence", 4'b1100, 2'b10);
        tick(2);
        chk("R10 sequence continues", 4'b1110, 2'b10);
        tick(3);
        chk("R10 full shown one cycle", 4'b1110, 2'b00);
        tick(1);
        chk("R10 latest held request applied", 4'b1100, 2'b01);
    endtask

    task automatic t_req_with_wake();
        send_req(2'b11);
        chk("R4 sleep from lvl2", 4'b0000, 2'b11);
        wake = 1'b1;
        req = 1'b1;
        code = 2'b10;
        tick(1);
        wake = 1'b0;
        req = 1'b0;
        code = 2'b00;
        chk("R11 ramp with request pending", 4'b1001, 2'b11);
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        tick(7);
        chk("R10 full after sleep wake", 4'b1110, 2'b00);
        tick(1);
        chk("R10 request from wake cycle applied", 4'b1000, 2'b10);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_ignored_in_full();
        t_descend();
        t_wake_lvl1();
        t_sleep_wake();
        t_wake_lvl2();
        t_held_req();
        t_req_with_wake();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule